// File: doc/BRIEF.md
# Branch Condition and Program-Counter Update Unit

This unit resolves control transfers for a processor with a 24-bit code space. That space is split into a 16-bit program counter and an 8-bit program-bank register. For each issued instruction the unit takes a decoded operation kind, a 5-bit condition selector, the N, Z, V, C and T status flags, an 8-bit signed displacement and the possible jump operands. It then updates its program counter and bank, reports whether control was transferred, and reports the instruction's execution cycle count.

Relative branches test one of sixteen flag conditions. These cover the single flags, the signed comparisons and the unsigned comparisons, each with its inverse. One extra code branches always. Near jumps replace only the 16-bit counter. Far jumps also reload the bank. The decoder, operand fetch and stack traffic sit outside the block. A 24-bit memory operand reaches the unit with the low word and the low byte of the following word already placed side by side.

Top module: `brpc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first issue, pc_q = 0, bank_q = 0, taken_q = 0 and cycles_q = 0.
- R2: With op_kind 0 (relative), cond_sel 0..9 branch respectively when Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0, T=1, T=0.
- R3: With op_kind 0, cond_sel 10 branches when N xor V = 1 and cond_sel 11 branches when it is 0. cond_sel 12 branches when (N xor V) or Z = 1 and cond_sel 13 branches when it is 0.
- R4: With op_kind 0, cond_sel 14 branches when C or Z = 1 and cond_sel 15 branches when it is 0.
- R5: With op_kind 0, cond_sel 16 always branches and cond_sel 17..31 never branch.
- R6: A taken relative branch sets pc_q to the old pc_q + 2 + sign-extended disp, modulo 2^16. bank_q is unchanged, including when the sum crosses the 16-bit boundary.
- R7: A relative branch that is not taken sets pc_q to the old pc_q + 2, modulo 2^16. taken_q shows the decision. cycles_q is 4 when taken and 3 when not.
- R8: Near jumps leave bank_q unchanged and set taken_q = 1. op_kind 1 loads pc_q from acc (2 cycles). op_kind 2 loads it from imm16 (3 cycles). op_kind 3 loads it from mem_opnd[15:0] (3 cycles).
- R9: op_kind 4 loads pc_q from imm24[15:0] and bank_q from imm24[23:16] (4 cycles). op_kind 5 loads pc_q from mem_opnd[15:0] and bank_q from mem_opnd[23:16] (5 cycles). Both set taken_q = 1.
- R10: In a cycle with issue low, all four outputs keep their values whatever the other inputs do.
- R11: An issue with op_kind 6 or 7 leaves pc_q and bank_q unchanged and sets taken_q = 0 and cycles_q = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| issue | input | 1 | Applies the presented instruction at this clock edge |
| op_kind | input | 3 | Operation kind: 0 relative, 1 accumulator, 2 imm16, 3 memory word, 4 far imm24, 5 far memory |
| cond_sel | input | 5 | Branch condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_t | input | 1 | Sticky flag |
| disp | input | 8 | Signed relative displacement |
| acc | input | 16 | Accumulator value |
| imm16 | input | 16 | 16-bit absolute target |
| imm24 | input | 24 | 24-bit absolute target |
| mem_opnd | input | 24 | Memory operand: target word and bank byte |
| pc_q | output | 16 | Program counter |
| bank_q | output | 8 | Program bank |
| taken_q | output | 1 | Last issued instruction transferred control |
| cycles_q | output | 4 | Execution cycles of last issued instruction |

## Verification
A taken relative branch performs two jobs in the same cycle. It adds the displacement to the counter, and it keeps the bank. The two meet when the sum carries out of 16 bits, forward or backward. The bench places the counter near 0xFFF0 and near 0x0003 with a far jump, then issues always-taken branches with displacements +127 and -128. It also issues a not-taken branch from 0xFFFE. It judges the wrapped counter and the untouched bank against its own model in the cycle after issue.

// File: rtl/brpc_pkg.sv
package brpc_pkg;

  typedef enum logic [2:0] {
    OPK_REL    = 3'd0,
    OPK_ACC    = 3'd1,
    OPK_ABS16  = 3'd2,
    OPK_WORD   = 3'd3,
    OPK_FAR24  = 3'd4,
    OPK_FARMEM = 3'd5,
    OPK_RSV6   = 3'd6,
    OPK_RSV7   = 3'd7
  } opk_e;

  localparam int SEL_W = 5;
  localparam int CYC_W = 4;

  // instruction length of a relative branch, in bytes
  localparam int LEN_REL = 2;

  // execution cycle counts per kind
  localparam int CYC_REL_TAKEN = 4;
  localparam int CYC_REL_SKIP  = 3;
  localparam int CYC_ACC       = 2;
  localparam int CYC_ABS16     = 3;
  localparam int CYC_WORD      = 3;
  localparam int CYC_FAR24     = 4;
  localparam int CYC_FARMEM    = 5;

endpackage

// File: rtl/brpc_cond_eval.sv
module brpc_cond_eval
  import brpc_pkg::*;
(
  input  logic             fl_n,
  input  logic             fl_z,
  input  logic             fl_v,
  input  logic             fl_c,
  input  logic             fl_t,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);

  localparam int NPAIR = 8;
  localparam int NCODE = 2 * NPAIR;

  logic [NPAIR-1:0] pair_true;
  logic [NCODE-1:0] code_hit;

  // pair order follows the selector encoding
  assign pair_true = {fl_c | fl_z,
                      (fl_v ^ fl_n) | fl_z,
                      fl_v ^ fl_n,
                      fl_t,
                      fl_v,
                      fl_n,
                      fl_c,
                      fl_z};

  for (genvar k = 0; k < NCODE; k++) begin : g_code
    if (k % 2 == 0) begin : g_pos
      assign code_hit[k] = pair_true[k/2];
    end else begin : g_neg
      assign code_hit[k] = ~pair_true[k/2];
    end
  end

  always_comb begin
    if (sel[SEL_W-1]) begin
      hit = (sel[SEL_W-2:0] == '0);
    end else begin
      hit = code_hit[sel[SEL_W-2:0]];
    end
  end

endmodule

// File: rtl/brpc_target_gen.sv
module brpc_target_gen
  import brpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DISP_W = 8
) (
  input  opk_e                     kind,
  input  logic                     cond_hit,
  input  logic [PC_W-1:0]          pc,
  input  logic [BANK_W-1:0]        bank,
  input  logic [DISP_W-1:0]        disp,
  input  logic [PC_W-1:0]          acc,
  input  logic [PC_W-1:0]          imm16,
  input  logic [PC_W+BANK_W-1:0]   imm24,
  input  logic [PC_W+BANK_W-1:0]   mem_opnd,
  output logic [PC_W-1:0]          nxt_pc,
  output logic [BANK_W-1:0]        nxt_bank,
  output logic                     taken
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] rel_pc;

  assign seq_pc   = pc + PC_W'(LEN_REL);
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rel_pc   = seq_pc + disp_ext;

  always_comb begin
    nxt_pc   = pc;
    nxt_bank = bank;
    taken    = 1'b0;
    case (kind)
      OPK_REL: begin
        taken  = cond_hit;
        nxt_pc = cond_hit ? rel_pc : seq_pc;
      end
      OPK_ACC: begin
        taken  = 1'b1;
        nxt_pc = acc;
      end
      OPK_ABS16: begin
        taken  = 1'b1;
        nxt_pc = imm16;
      end
      OPK_WORD: begin
        taken  = 1'b1;
        nxt_pc = mem_opnd[PC_W-1:0];
      end
      OPK_FAR24: begin
        taken    = 1'b1;
        nxt_pc   = imm24[PC_W-1:0];
        nxt_bank = imm24[PC_W+BANK_W-1:PC_W];
      end
      OPK_FARMEM: begin
        taken    = 1'b1;
        nxt_pc   = mem_opnd[PC_W-1:0];
        nxt_bank = mem_opnd[PC_W+BANK_W-1:PC_W];
      end
      default: begin
        taken = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brpc_cycle_cost.sv
module brpc_cycle_cost
  import brpc_pkg::*;
(
  input  opk_e             kind,
  input  logic             taken,
  output logic [CYC_W-1:0] cycles
);

  always_comb begin
    case (kind)
      OPK_REL:    cycles = taken ? CYC_W'(CYC_REL_TAKEN) : CYC_W'(CYC_REL_SKIP);
      OPK_ACC:    cycles = CYC_W'(CYC_ACC);
      OPK_ABS16:  cycles = CYC_W'(CYC_ABS16);
      OPK_WORD:   cycles = CYC_W'(CYC_WORD);
      OPK_FAR24:  cycles = CYC_W'(CYC_FAR24);
      OPK_FARMEM: cycles = CYC_W'(CYC_FARMEM);
      default:    cycles = '0;
    endcase
  end

endmodule

// File: rtl/brpc_unit.sv
module brpc_unit
  import brpc_pkg::*;
#(
  parameter int                PC_W       = 16,
  parameter int                BANK_W     = 8,
  parameter int                DISP_W     = 8,
  parameter logic [PC_W-1:0]   RESET_PC   = '0,
  parameter logic [BANK_W-1:0] RESET_BANK = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue,
  input  logic [2:0]             op_kind,
  input  logic [SEL_W-1:0]       cond_sel,
  input  logic                   flag_n,
  input  logic                   flag_z,
  input  logic                   flag_v,
  input  logic                   flag_c,
  input  logic                   flag_t,
  input  logic [DISP_W-1:0]      disp,
  input  logic [PC_W-1:0]        acc,
  input  logic [PC_W-1:0]        imm16,
  input  logic [PC_W+BANK_W-1:0] imm24,
  input  logic [PC_W+BANK_W-1:0] mem_opnd,
  output logic [PC_W-1:0]        pc_q,
  output logic [BANK_W-1:0]      bank_q,
  output logic                   taken_q,
  output logic [CYC_W-1:0]       cycles_q
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short shift chain
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  opk_e               kind;
  logic               cond_hit;
  logic [PC_W-1:0]    gen_pc;
  logic [BANK_W-1:0]  gen_bank;
  logic               gen_taken;
  logic [CYC_W-1:0]   gen_cycles;

  assign kind = opk_e'(op_kind);

  brpc_cond_eval u_cond (
    .fl_n (flag_n),
    .fl_z (flag_z),
    .fl_v (flag_v),
    .fl_c (flag_c),
    .fl_t (flag_t),
    .sel  (cond_sel),
    .hit  (cond_hit)
  );

  brpc_target_gen #(
    .PC_W   (PC_W),
    .BANK_W (BANK_W),
    .DISP_W (DISP_W)
  ) u_target (
    .kind     (kind),
    .cond_hit (cond_hit),
    .pc       (pc_q),
    .bank     (bank_q),
    .disp     (disp),
    .acc      (acc),
    .imm16    (imm16),
    .imm24    (imm24),
    .mem_opnd (mem_opnd),
    .nxt_pc   (gen_pc),
    .nxt_bank (gen_bank),
    .taken    (gen_taken)
  );

  brpc_cycle_cost u_cost (
    .kind   (kind),
    .taken  (gen_taken),
    .cycles (gen_cycles)
  );

  // next-state selection
  logic [PC_W-1:0]   pc_d;
  logic [BANK_W-1:0] bank_d;
  logic              taken_d;
  logic [CYC_W-1:0]  cycles_d;

  always_comb begin
    pc_d     = pc_q;
    bank_d   = bank_q;
    taken_d  = taken_q;
    cycles_d = cycles_q;
    if (issue) begin
      pc_d     = gen_pc;
      bank_d   = gen_bank;
      taken_d  = gen_taken;
      cycles_d = gen_cycles;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q     <= RESET_PC;
      bank_q   <= RESET_BANK;
      taken_q  <= 1'b0;
      cycles_q <= '0;
    end else if (issue) begin
      pc_q     <= pc_d;
      bank_q   <= bank_d;
      taken_q  <= taken_d;
      cycles_q <= cycles_d;
    end
  end

endmodule

// File: rtl/brpc_unit_chk.sv
module brpc_unit_chk
  import brpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   issue,
  input logic [2:0]             op_kind,
  input logic [SEL_W-1:0]       cond_sel,
  input logic                   flag_z,
  input logic [PC_W+BANK_W-1:0] imm24,
  input logic [PC_W-1:0]        pc_q,
  input logic [BANK_W-1:0]      bank_q,
  input logic                   taken_q,
  input logic [CYC_W-1:0]       cycles_q
);

  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind == 3'd0 && cond_sel == 5'd0 |=> taken_q == $past(flag_z)); // R2

  AST_NEVER_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind == 3'd0 && cond_sel > 5'd16
    |=> !taken_q && pc_q == $past(pc_q) + PC_W'(2)); // R5

  AST_REL_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind == 3'd0 |=> $stable(bank_q)); // R6

  AST_REL_COST: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind == 3'd0
    |=> cycles_q == (taken_q ? CYC_W'(4) : CYC_W'(3))); // R7

  AST_NEAR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind >= 3'd1 && op_kind <= 3'd3 |=> $stable(bank_q) && taken_q); // R8

  AST_FAR_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind == 3'd4
    |=> pc_q == $past(imm24[PC_W-1:0]) && bank_q == $past(imm24[PC_W+BANK_W-1:PC_W])
        && cycles_q == CYC_W'(4)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(pc_q) && $stable(bank_q) && $stable(taken_q) && $stable(cycles_q)); // R10

  AST_RSV_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_kind >= 3'd6
    |=> $stable(pc_q) && $stable(bank_q) && !taken_q && cycles_q == '0); // R11

endmodule

bind brpc_unit brpc_unit_chk #(
  .PC_W   (PC_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .issue    (issue),
  .op_kind  (op_kind),
  .cond_sel (cond_sel),
  .flag_z   (flag_z),
  .imm24    (imm24),
  .pc_q     (pc_q),
  .bank_q   (bank_q),
  .taken_q  (taken_q),
  .cycles_q (cycles_q)
);

// File: tb/tb_brpc_unit.sv
module tb_brpc_unit;

  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [2:0]  op_kind;
  logic [4:0]  cond_sel;
  logic        flag_n, flag_z, flag_v, flag_c, flag_t;
  logic [7:0]  disp;
  logic [15:0] acc;
  logic [15:0] imm16;
  logic [23:0] imm24;
  logic [23:0] mem_opnd;
  logic [15:0] pc_q;
  logic [7:0]  bank_q;
  logic        taken_q;
  logic [3:0]  cycles_q;

  int n_vec  = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_pc   = 0;
  int m_bank = 0;
  int m_tk   = 0;
  int m_cyc  = 0;

  brpc_unit dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .op_kind  (op_kind),
    .cond_sel (cond_sel),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .flag_t   (flag_t),
    .disp     (disp),
    .acc      (acc),
    .imm16    (imm16),
    .imm24    (imm24),
    .mem_opnd (mem_opnd),
    .pc_q     (pc_q),
    .bank_q   (bank_q),
    .taken_q  (taken_q),
    .cycles_q (cycles_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_cond(int sel, bit n, bit z, bit v, bit c, bit t);
    case (sel)
      0:  return z;
      1:  return !z;
      2:  return c;
      3:  return !c;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return t;
      9:  return !t;
      10: return n != v;
      11: return n == v;
      12: return (n != v) || z;
      13: return !((n != v) || z);
      14: return c || z;
      15: return !(c || z);
      16: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare(input string req);
    n_vec++;
    if (int'(pc_q) != m_pc || int'(bank_q) != m_bank ||
        int'(taken_q) != m_tk || int'(cycles_q) != m_cyc) begin
      n_fail++;
      $display("FAIL %s: pc=%h bank=%h taken=%0d cyc=%0d expected pc=%h bank=%h taken=%0d cyc=%0d",
               req, pc_q, bank_q, taken_q, cycles_q, m_pc, m_bank, m_tk, m_cyc);
    end
  endtask

  // one issued instruction, preceded by an idle cycle that is also checked
  task automatic apply(input int kind, input int sel, input int fl, input int d,
                       input int a, input int i16, input int i24, input int mem,
                       input string req);
    int dd;
    @(negedge clk);
    compare("R10 hold before issue");
    op_kind  = 3'(kind);
    cond_sel = 5'(sel);
    {flag_n, flag_z, flag_v, flag_c, flag_t} = 5'(fl);
    disp     = 8'(d);
    acc      = 16'(a);
    imm16    = 16'(i16);
    imm24    = 24'(i24);
    mem_opnd = 24'(mem);
    issue    = 1'b1;
    case (kind)
      0: begin
        m_tk = int'(ref_cond(sel, fl[4], fl[3], fl[2], fl[1], fl[0]));
        dd   = (d & 255) >= 128 ? (d & 255) - 256 : (d & 255);
        m_pc = m_tk != 0 ? (m_pc + 2 + dd) & 65535 : (m_pc + 2) & 65535;
        m_cyc = m_tk != 0 ? 4 : 3;
      end
      1: begin m_pc = a & 65535;   m_tk = 1; m_cyc = 2; end
      2: begin m_pc = i16 & 65535; m_tk = 1; m_cyc = 3; end
      3: begin m_pc = mem & 65535; m_tk = 1; m_cyc = 3; end
      4: begin
        m_pc = i24 & 65535; m_bank = (i24 >> 16) & 255; m_tk = 1; m_cyc = 4;
      end
      5: begin
        m_pc = mem & 65535; m_bank = (mem >> 16) & 255; m_tk = 1; m_cyc = 5;
      end
      default: begin m_tk = 0; m_cyc = 0; end
    endcase
    @(negedge clk);
    issue = 1'b0;
    compare(req);
  endtask

  // inputs move while issue stays low
  task automatic idle_noise;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_kind  = 3'(k + 3);
      cond_sel = 5'(k * 5 + 16);
      acc      = 16'(16'h1111 * (k + 1));
      imm24    = 24'(24'h0A0B0C * (k + 1));
      mem_opnd = 24'(24'h123456 + k);
      disp     = 8'(k * 40);
      compare("R10 idle inputs ignored");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : main
    string req;
    rst_n = 1'b0;
    issue = 1'b0;
    op_kind = '0; cond_sel = '0;
    {flag_n, flag_z, flag_v, flag_c, flag_t} = '0;
    disp = '0; acc = '0; imm16 = '0; imm24 = '0; mem_opnd = '0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release");

    apply(4, 0, 0, 0, 0, 0, 24'h124000, 0, "R9 far imm24");

    // every selector against every flag combination
    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 32; f++) begin
        if (s < 10)       req = "R2 flag pair";
        else if (s < 14)  req = "R3 signed pair";
        else if (s < 16)  req = "R4 unsigned pair";
        else              req = "R5 always/never";
        apply(0, s, f, (s * 7 + f * 13) & 255, 0, 0, 0, 0, {req, " R6 R7"});
      end
    end

    // boundary crossings
    apply(4, 0, 0, 0, 0, 0, 24'h7EFFF0, 0, "R9 set near top");
    apply(0, 16, 0, 8'h7F, 0, 0, 0, 0, "R6 forward wrap keeps bank");
    apply(4, 0, 0, 0, 0, 0, 24'h7E0003, 0, "R9 set near bottom");
    apply(0, 16, 0, 8'h80, 0, 0, 0, 0, "R6 backward wrap keeps bank");
    apply(4, 0, 0, 0, 0, 0, 24'h55FFFE, 0, "R9 set at top");
    apply(0, 31, 5'h1F, 8'h10, 0, 0, 0, 0, "R7 not-taken wrap");

    // near jumps
    apply(1, 0, 0, 0, 16'h1234, 16'hFFFF, 24'hFFFFFF, 24'hFFFFFF, "R8 acc");
    apply(2, 0, 0, 0, 16'h0, 16'hBEEF, 24'hFFFFFF, 24'hFFFFFF, "R8 imm16");
    apply(3, 0, 0, 0, 16'h0, 16'h0, 24'hFFFFFF, 24'hA5A5A5, "R8 memory word");

    // far memory jump
    apply(5, 0, 0, 0, 0, 0, 0, 24'h33C0DE, "R9 far memory");

    // reserved kinds
    apply(6, 16, 5'h1F, 8'h44, 16'h9999, 16'h8888, 24'h777777, 24'h666666, "R11 kind 6");
    apply(7, 16, 5'h1F, 8'h44, 16'h9999, 16'h8888, 24'h777777, 24'h666666, "R11 kind 7");

    idle_noise();
    apply(0, 16, 0, 8'h02, 0, 0, 0, 0, "R6 after idle");
    idle_noise();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule